// File: doc/BRIEF.md
# Ping-Pong Sample Block Buffer

This block sits between a producer of complex samples and a host that reads them a byte at a time. It holds two banks. The producer writes into one bank (the fill bank), and the host reads the other bank (the read bank). Each sample is an in-phase word and a quadrature word, each 32 bits wide, written together under a valid strobe. When the fill bank has received a full block of one, two or four samples, the two banks change roles in a single cycle. The block that just completed then becomes readable as a whole.

The host reads through a byte-addressed window. The window is split over two pages, and each page exposes offsets 16 to 31. The host signals that it has finished with the current read bank by pulsing a read-done strobe. If a new block completes before that strobe has arrived, the block the host had not yet consumed is replaced, and a sticky overflow flag is raised. The host clears the flag by writing a zero to it.

Top module: `pingpong_sample_buf`

## Requirements
- R1: A synchronous reset clears both banks, selects bank 0 for reading, restarts the fill count and clears the overflow flag. After reset every byte reads back as zero.
- R2: Sample k of a block stores its I word at word index 2k and its Q word at word index 2k+1. Words are little-endian, with byte n of the bank being bits 8*(n%4)+7 down to 8*(n%4) of word n/4. Page 0 (rd_page=0) exposes bank bytes 0 to 15 and page 1 exposes bytes 16 to 31, at offset 16+(n%16).
- R3: The block-size code selects how many samples make up a block. Codes 0 and 1 select one sample, code 2 selects two samples and code 3 selects four samples.
- R4: The read bank does not change while a block is filling. The cycle after the final sample of a block is written, the banks swap and the completed block is what the host reads.
- R5: When a block completes and no read-done has been seen since the previous swap, the overflow flag is set on the next cycle. The first block after reset never sets it.
- R6: A read-done pulse in the same cycle as the final write of a block counts as an acknowledgement of the old block. A read-done pulse that arrives before the swap acknowledges only the block being read at that moment.
- R7: The overflow flag is sticky. A flag write with data 0 clears it, and a flag write with data 1 has no effect. If an overflow and a clear happen in the same cycle, the flag ends up set.
- R8: Read offsets 0 to 15 return 0x00 on either page.
- R9: Word positions beyond the current block size keep whatever that bank last held.
- R10: If the block-size code is lowered while a block is filling and the count already reaches the new size, the next valid write completes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Sample write strobe |
| wr_i | input | 32 | In-phase word |
| wr_q | input | 32 | Quadrature word |
| blk_code | input | 2 | Block-size code |
| rd_page | input | 1 | Read page select |
| rd_addr | input | 5 | Byte offset within page |
| rd_data | output | 8 | Read byte (combinational) |
| rd_done | input | 1 | Host finished with read bank |
| ovf_we | input | 1 | Overflow flag write strobe |
| ovf_wdata | input | 1 | Overflow flag write data |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets three kinds of corner case.

- **Swap timing:** it reads the window on every cycle while a block fills. A design that swapped one sample early, or wrote into the exposed bank, would show partial blocks.
- **Read-done coincident with the last write:** this case catches a design that samples the acknowledgement one cycle late and flags a false overflow. The set-versus-clear collision catches a flag whose clear wins.
- **Stale words and the mid-block change of size code:** a one-sample block must leave the higher words of its bank untouched. A design that compares the count for equality instead of reaching the new size would overrun the bank and never swap.

// File: rtl/pingpong_sample_buf.sv
module pingpong_sample_buf #(
  parameter int WORD_W   = 32,
  parameter int MAX_SAMP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_i,
  input  logic [WORD_W-1:0] wr_q,
  input  logic [1:0]        blk_code,
  input  logic              rd_page,
  input  logic [4:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              rd_done,
  input  logic              ovf_we,
  input  logic              ovf_wdata,
  output logic              ovf_flag
);
  localparam int WORDS = 2 * MAX_SAMP;
  localparam int CW    = $clog2(MAX_SAMP);
  localparam int WA    = $clog2(WORDS);
  localparam int BPW   = WORD_W / 8;
  localparam int BA    = $clog2(BPW);

  logic [WORD_W-1:0] mem [2][WORDS];
  logic          rd_bank;
  logic [CW-1:0] cnt;
  logic          host_done;
  logic          ovf_q;
  logic [CW:0]   last_idx;
  logic          blk_end;
  logic          acked;
  logic [4:0]    bidx;
  logic [WORD_W-1:0] rword;

  always_comb begin
    case (blk_code)
      2'd2:    last_idx = (CW+1)'(1);
      2'd3:    last_idx = (CW+1)'(MAX_SAMP - 1);
      default: last_idx = '0;
    endcase
  end

  assign blk_end = wr_valid && ({1'b0, cnt} >= last_idx);
  assign acked   = host_done || rd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WORDS; w++)
          mem[b][w] <= '0;
      rd_bank   <= 1'b0;
      cnt       <= '0;
      host_done <= 1'b1;
      ovf_q     <= 1'b0;
    end else begin
      if (wr_valid) begin
        mem[~rd_bank][WA'({cnt, 1'b0})] <= wr_i;
        mem[~rd_bank][WA'({cnt, 1'b1})] <= wr_q;
      end
      if (blk_end) begin
        rd_bank <= ~rd_bank;
        cnt     <= '0;
      end else if (wr_valid) begin
        cnt <= cnt + 1'b1;
      end
      host_done <= blk_end ? 1'b0 : acked;
      if (blk_end && !acked)
        ovf_q <= 1'b1;
      else if (ovf_we && !ovf_wdata)
        ovf_q <= 1'b0;
    end
  end

  assign bidx     = {rd_page, rd_addr[3:0]};
  assign rword    = mem[rd_bank][WA'(bidx >> BA)];
  assign rd_data  = rd_addr[4] ? rword[8*bidx[BA-1:0] +: 8] : 8'h00;
  assign ovf_flag = ovf_q;

endmodule

module pingpong_sample_buf_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic [1:0] blk_code,
  input logic [4:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       ovf_we,
  input logic       ovf_wdata,
  input logic       ovf_flag,
  input logic       rd_bank
);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(ovf_we && !ovf_wdata)) |=> ovf_flag);
  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_we && !ovf_wdata && !wr_valid) |=> !ovf_flag);
  // R5
  ovf_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !wr_valid) |=> !ovf_flag);
  // R3
  single_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && blk_code < 2'd2) |=> (rd_bank != $past(rd_bank)));
  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(rd_bank));
  // R8
  low_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr < 5'd16) |-> (rd_data == 8'h00));
endmodule

bind pingpong_sample_buf pingpong_sample_buf_chk u_chk (.*);

// File: tb/test_pingpong_sample_buf.sv
`timescale 1ns/1ps
module test_pingpong_sample_buf;
  logic clk = 0, rst = 1, wr_valid = 0, rd_page = 0, rd_done = 0, ovf_we = 0, ovf_wdata = 0;
  logic [31:0] wr_i = 0, wr_q = 0;
  logic [1:0] blk_code = 3;
  logic [4:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic ovf_flag;
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pingpong_sample_buf i_pingpong_sample_buf (.*);

  logic [31:0] m_bank [2][8];
  bit m_rdb, m_done, m_ovf;
  int m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_bank[b, w]) m_bank[b][w] = 0;
      m_rdb = 0; m_done = 1; m_ovf = 0; m_cnt = 0;
    end else begin
      int n;
      if (ovf_we && !ovf_wdata) m_ovf = 0;
      if (rd_done) m_done = 1;
      if (wr_valid) begin
        n = (blk_code == 3) ? 4 : (blk_code == 2) ? 2 : 1;
        m_bank[!m_rdb][2*m_cnt]   = wr_i;
        m_bank[!m_rdb][2*m_cnt+1] = wr_q;
        if (m_cnt >= n - 1) begin
          if (!m_done) m_ovf = 1;
          m_done = 0; m_rdb = !m_rdb; m_cnt = 0;
        end else m_cnt++;
      end
    end
  end

  function automatic logic [7:0] exp_byte();
    int idx;
    logic [31:0] w;
    if (!rd_addr[4]) return 8'h00;
    idx = {rd_page, rd_addr[3:0]};
    w = m_bank[m_rdb][idx / 4];
    return w[8*(idx % 4) +: 8];
  endfunction

  task automatic step(string req);
    #1;
    vectors++;
    if (rd_data !== exp_byte() || ovf_flag !== m_ovf) begin
      miscompares++;
      $display("FAIL %s: page %0d off %0d data %h ovf %b, expected data %h ovf %b",
               req, rd_page, rd_addr, rd_data, ovf_flag, exp_byte(), m_ovf);
    end
    @(negedge clk);
  endtask

  task automatic put(logic [31:0] i, logic [31:0] q, string req);
    wr_valid = 1; wr_i = i; wr_q = q;
    rd_addr = 5'(16 + (i % 16)); rd_page = i[4];
    step(req);
    wr_valid = 0;
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 32; a++) begin
        rd_page = p[0]; rd_addr = a[4:0];
        step(req);
      end
  endtask

  task automatic ack();
    rd_done = 1; step("R6"); rd_done = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset contents and R8 low offsets
    sweep("R1");
    // R2 R4 four-sample block, first after reset: no overflow (R5)
    blk_code = 3;
    for (int k = 0; k < 4; k++) put(32'h1000_0000 + k*32'h0102_0304, 32'hA0B0_C0D0 + k, "R4");
    sweep("R2");
    ack();
    // R3 code 2: two-sample block, acknowledged -> no overflow
    blk_code = 2;
    put(32'h2222_0001, 32'h3333_0001, "R3");
    put(32'h2222_0002, 32'h3333_0002, "R3");
    sweep("R9");
    // R5 no read-done -> overflow
    put(32'h4444_0001, 32'h5555_0001, "R5");
    put(32'h4444_0002, 32'h5555_0002, "R5");
    step("R5");
    // R7 write 1 has no effect, write 0 clears
    ovf_we = 1; ovf_wdata = 1; step("R7");
    ovf_wdata = 0; step("R7");
    ovf_we = 0; step("R7");
    // R6 read-done coincident with final write
    put(32'h6666_0001, 32'h7777_0001, "R6");
    rd_done = 1;
    put(32'h6666_0002, 32'h7777_0002, "R6");
    rd_done = 0;
    step("R6");
    // R7 set wins over clear
    ovf_we = 1; ovf_wdata = 0;
    put(32'h8888_0001, 32'h9999_0001, "R7");
    put(32'h8888_0002, 32'h9999_0002, "R7");
    ovf_we = 0;
    step("R7");
    ovf_we = 1; step("R7"); ovf_we = 0;
    // R3 codes 0 and 1 single-sample blocks, R9 stale words
    ack();
    blk_code = 0; put(32'hC0DE_0000, 32'hFACE_0000, "R3"); ack(); sweep("R9");
    blk_code = 1; put(32'hC0DE_0001, 32'hFACE_0001, "R3"); ack(); sweep("R9");
    // R10 lower the code mid-block
    blk_code = 3;
    for (int k = 0; k < 3; k++) put(32'hD000_0000 + k, 32'hE000_0000 + k, "R10");
    blk_code = 2;
    put(32'hD000_0003, 32'hE000_0003, "R10");
    sweep("R10");
    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      wr_valid = ($urandom % 3) == 0;
      wr_i = $urandom; wr_q = $urandom;
      blk_code = 2'($urandom);
      rd_page = 1'($urandom); rd_addr = 5'($urandom);
      rd_done = ($urandom % 5) == 0;
      ovf_we = ($urandom % 7) == 0; ovf_wdata = 1'($urandom);
      step("R4");
    end
    wr_valid = 0; rd_done = 0; ovf_we = 0;
    sweep("R2");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule